// File: doc/BRIEF.md
# Hardware Trap Controller

This block sits next to a 16-bit CPU core and turns exception and error events into branch requests. Each hardware trap cause raises its own bit in a flag register. The bit stays set until software clears it. The block also keeps a separate pending copy of each cause. It chooses the most urgent pending trap and tells the core where to branch. For each request it gives the trap number, the class priority and a full vector address. That address joins a programmable segment value with an offset equal to four times the trap number.

Traps fall into three fixed priority levels. Reset-class events (software reset, watchdog overflow) are the highest level and use trap number 0x00. Four class-A causes are the middle level, and each has its own number. Four class-B causes are the lowest level, and all of them share one number. The core tells them apart by reading the flag register. A software trap instruction can ask for any number from 0x00 to 0x7F. It carries no class priority and does not open a trap service.

A small stack records the class level of every hardware trap service that is open. A pending trap is dispatched only when its class is strictly higher than the level on top of that stack. The core pops the stack with a return strobe. While any hardware service is open, the block tells the standard interrupt controller to hold off.

Top module: `trap_ctrl`

## Requirements
- R1: A 1 on `evt_i[k]` sets `flags_o[k]` after the next clock edge. The bit stays set until a cycle with `clr_we_i`=1 and `clr_mask_i[k]`=1. That clear leaves the other bits unchanged. Bits 0..3 are class-A causes and bits 4..7 are class-B causes.
- R2: If a clear and a new event hit the same flag bit in the same cycle, the bit stays set.
- R3: A reset-class event (`rst_evt_i`) produces a request with trap number 0x00, vector offset 0x0000 and priority 3.
- R4: Class-A cause k (0..3) produces trap number 2+2k with priority 2. When several class-A causes are pending, the lowest trap number is served first. Each later one is served as soon as the service before it is popped.
- R5: Any set of pending class-B causes produces one request with trap number 0x0A and priority 1. All of their flag bits stay set.
- R6: `vec_addr_o` equals the segment input, sampled on the dispatch edge, in the upper bits, followed by the 16-bit offset trap number × 4.
- R7: A software trap with number n (0..0x7F) produces a request with trap number n, offset n×4 and priority 0. It does not open a hardware trap service.
- R8: A pending hardware trap is dispatched only when its priority is strictly higher than the level on top of the active stack, or when that stack is empty. A blocked trap stays pending and is served once enough returns (`ret_i`) lower the top level.
- R9: `irq_block_o` is 1 exactly while at least one hardware trap service is open.
- R10: An event sampled on clock edge k gives `req_o`=1 after edge k+1, for one cycle only, unless a further request follows.
- R11: If a hardware trap and a software trap become pending together, the hardware trap is requested first and the software trap on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Hardware cause events; bits 0..3 class A, bits 4..7 class B |
| rst_evt_i | input | 1 | Reset-class event (software reset or watchdog overflow) |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 8 | Flag bits to clear when `clr_we_i` is 1 |
| sw_trap_i | input | 1 | Software trap instruction strobe |
| sw_num_i | input | 7 | Trap number of the software trap |
| ret_i | input | 1 | Return from a hardware trap service; pops the active stack |
| seg_i | input | SEG_W (8) | Vector table segment |
| flags_o | output | 8 | Trap flag register |
| req_o | output | 1 | One-cycle branch request |
| trap_num_o | output | 7 | Trap number of the request |
| prio_o | output | 2 | Priority of the request (3 reset, 2 class A, 1 class B, 0 software) |
| vec_addr_o | output | SEG_W+16 (24) | Segment joined with the vector offset |
| irq_block_o | output | 1 | Hold-off for standard interrupts while a trap service is open |

## Verification
The bench raises each single hardware cause in turn, which checks the trap number, the class and the vector for every bit position. It then sweeps all 15 non-empty subsets of class-A causes; this confirms that the lowest number is served first and that same-class traps wait for a return. One test raises all class-B causes together, which shows that a single shared request is made while every flag bit stays set. Nesting sequences raise a trap above, equal to and below the active level to test preemption, and a full sweep of the 128 software trap numbers checks vector arithmetic and shows that the interrupt hold-off is left alone. Same-cycle hardware and software traps, and same-cycle clears and events, test the two tie rules.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int CLS_A_N = 4;
    localparam int CLS_B_N = 4;
    localparam int FLAG_W  = CLS_A_N + CLS_B_N;
    localparam int TNUM_W  = 7;
    localparam int PRIO_W  = 2;
    localparam int OFS_W   = 16;
    localparam int A_IW    = $clog2(CLS_A_N);

    typedef enum logic [PRIO_W-1:0] {
        LVL_NONE = 2'd0,
        LVL_B    = 2'd1,
        LVL_A    = 2'd2,
        LVL_RST  = 2'd3
    } lvl_e;

    localparam logic [TNUM_W-1:0] TNUM_RST    = 7'h00;
    localparam logic [TNUM_W-1:0] TNUM_A_BASE = 7'h02;
    localparam logic [TNUM_W-1:0] TNUM_B      = 7'h0A;

    typedef struct packed {
        logic              vld;
        lvl_e              lvl;
        logic [TNUM_W-1:0] num;
    } cand_t;

    function automatic logic [OFS_W-1:0] num2ofs(input logic [TNUM_W-1:0] n);
        return {{(OFS_W-TNUM_W-2){1'b0}}, n, 2'b00};
    endfunction

    function automatic logic [TNUM_W-1:0] a_num(input logic [A_IW-1:0] idx);
        return TNUM_A_BASE + {{(TNUM_W-A_IW-1){1'b0}}, idx, 1'b0};
    endfunction
endpackage

// File: rtl/trap_flag_bank.sv
module trap_flag_bank
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] evt_i,
    input  logic              rst_evt_i,
    input  logic              clr_we_i,
    input  logic [FLAG_W-1:0] clr_mask_i,
    input  logic [FLAG_W-1:0] take_mask_i,
    input  logic              take_rst_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] pend_o,
    output logic              rst_pend_o
);
    logic [FLAG_W-1:0] clr_eff;

    // clearing happens first; a simultaneous event then sets the bit again
    assign clr_eff = clr_we_i ? clr_mask_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o    <= '0;
            pend_o     <= '0;
            rst_pend_o <= 1'b0;
        end else begin
            flags_o    <= (flags_o & ~clr_eff) | evt_i;
            pend_o     <= (pend_o & ~take_mask_i) | evt_i;
            rst_pend_o <= (rst_pend_o & ~take_rst_i) | rst_evt_i;
        end
    end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic [FLAG_W-1:0] pend_i,
    input  logic              rst_pend_i,
    input  lvl_e              top_i,
    input  logic              room_i,
    output cand_t             cand_o,
    output logic              grant_o,
    output logic [FLAG_W-1:0] take_mask_o,
    output logic              take_rst_o
);
    logic            a_found;
    logic [A_IW-1:0] a_idx;

    always_comb begin
        a_found = 1'b0;
        a_idx   = '0;
        // scanning downward leaves the lowest pending index selected
        for (int i = CLS_A_N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                a_found = 1'b1;
                a_idx   = A_IW'(i);
            end
        end

        if (rst_pend_i)
            cand_o = '{vld: 1'b1, lvl: LVL_RST, num: TNUM_RST};
        else if (a_found)
            cand_o = '{vld: 1'b1, lvl: LVL_A, num: a_num(a_idx)};
        else if (|pend_i[FLAG_W-1:CLS_A_N])
            cand_o = '{vld: 1'b1, lvl: LVL_B, num: TNUM_B};
        else
            cand_o = '{vld: 1'b0, lvl: LVL_NONE, num: '0};

        grant_o = cand_o.vld && (cand_o.lvl > top_i) && room_i;

        take_mask_o = '0;
        take_rst_o  = 1'b0;
        if (grant_o) begin
            case (cand_o.lvl)
                LVL_RST: take_rst_o = 1'b1;
                LVL_A:   take_mask_o[a_idx] = 1'b1;
                LVL_B:   take_mask_o[FLAG_W-1:CLS_A_N] = pend_i[FLAG_W-1:CLS_A_N];
                default: take_rst_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/trap_nest_stack.sv
module trap_nest_stack
    import trap_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  lvl_e push_lvl_i,
    input  logic pop_i,
    output lvl_e top_o,
    output logic busy_o,
    output logic full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    lvl_e             stk [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic             pop_eff;
    logic [CNT_W-1:0] wr_idx;
    logic [CNT_W-1:0] top_idx;

    assign pop_eff = pop_i && (cnt != '0);
    assign wr_idx  = cnt - CNT_W'(pop_eff);
    assign top_idx = cnt - 1'b1;
    assign busy_o  = (cnt != '0);
    assign full_o  = (cnt == CNT_W'(DEPTH));
    assign top_o   = busy_o ? stk[top_idx] : LVL_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= LVL_NONE;
        end else begin
            if (push_i) stk[wr_idx] <= push_lvl_i;
            cnt <= wr_idx + CNT_W'(push_i);
        end
    end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int SEG_W      = 8,
    parameter int NEST_DEPTH = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              evt_i,
    input  logic                    rst_evt_i,
    input  logic                    clr_we_i,
    input  logic [7:0]              clr_mask_i,
    input  logic                    sw_trap_i,
    input  logic [6:0]              sw_num_i,
    input  logic                    ret_i,
    input  logic [SEG_W-1:0]        seg_i,
    output logic [7:0]              flags_o,
    output logic                    req_o,
    output logic [6:0]              trap_num_o,
    output logic [1:0]              prio_o,
    output logic [SEG_W+OFS_W-1:0]  vec_addr_o,
    output logic                    irq_block_o
);
    logic [FLAG_W-1:0] pend;
    logic              rst_pend;
    logic [FLAG_W-1:0] take_mask;
    logic              take_rst;
    cand_t             cand;
    logic              grant;
    lvl_e              top_lvl;
    logic              stk_full;
    logic              hw_go;
    logic              sw_vld;
    logic [TNUM_W-1:0] sw_num;

    trap_flag_bank u_flags (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt_i),
        .rst_evt_i   (rst_evt_i),
        .clr_we_i    (clr_we_i),
        .clr_mask_i  (clr_mask_i),
        .take_mask_i (take_mask),
        .take_rst_i  (take_rst),
        .flags_o     (flags_o),
        .pend_o      (pend),
        .rst_pend_o  (rst_pend)
    );

    trap_arbiter u_arb (
        .pend_i      (pend),
        .rst_pend_i  (rst_pend),
        .top_i       (top_lvl),
        .room_i      (!stk_full || ret_i),
        .cand_o      (cand),
        .grant_o     (grant),
        .take_mask_o (take_mask),
        .take_rst_o  (take_rst)
    );

    assign hw_go = grant;

    trap_nest_stack #(.DEPTH(NEST_DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push_i     (hw_go),
        .push_lvl_i (cand.lvl),
        .pop_i      (ret_i),
        .top_o      (top_lvl),
        .busy_o     (irq_block_o),
        .full_o     (stk_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o      <= 1'b0;
            trap_num_o <= '0;
            prio_o     <= '0;
            vec_addr_o <= '0;
            sw_vld     <= 1'b0;
            sw_num     <= '0;
        end else begin
            req_o <= 1'b0;
            if (hw_go) begin
                req_o      <= 1'b1;
                trap_num_o <= cand.num;
                prio_o     <= cand.lvl;
                vec_addr_o <= {seg_i, num2ofs(cand.num)};
            end else if (sw_vld) begin
                req_o      <= 1'b1;
                trap_num_o <= sw_num;
                prio_o     <= LVL_NONE;
                vec_addr_o <= {seg_i, num2ofs(sw_num)};
            end
            // a software trap waits while a hardware trap takes the slot
            sw_vld <= sw_trap_i | (sw_vld & hw_go);
            if (sw_trap_i) sw_num <= sw_num_i;
        end
    end
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
    import trap_pkg::*;
#(
    parameter int SEG_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [7:0]             evt_i,
    input logic                   clr_we_i,
    input logic [7:0]             clr_mask_i,
    input logic [SEG_W-1:0]       seg_i,
    input logic [7:0]             flags_o,
    input logic                   req_o,
    input logic [6:0]             trap_num_o,
    input logic [1:0]             prio_o,
    input logic [SEG_W+OFS_W-1:0] vec_addr_o,
    input logic                   irq_block_o
);
    p_flag_hold_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(flags_o) & ~($past(clr_we_i) ? $past(clr_mask_i) : 8'h00)) & ~flags_o) == 8'h00));

    p_evt_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_i != 8'h00) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

    p_rst_num_r3: assert property (@(posedge clk) disable iff (rst)
        (req_o && prio_o == 2'd3) |-> (trap_num_o == 7'h00));

    p_clsa_num_r4: assert property (@(posedge clk) disable iff (rst)
        (req_o && prio_o == 2'd2) |-> (trap_num_o inside {7'h02, 7'h04, 7'h06, 7'h08}));

    p_clsb_num_r5: assert property (@(posedge clk) disable iff (rst)
        (req_o && prio_o == 2'd1) |-> (trap_num_o == 7'h0A));

    p_vec_ofs_r6: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (vec_addr_o[OFS_W-1:0] == {7'b0, trap_num_o, 2'b00}));

    p_vec_seg_r6: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (vec_addr_o[SEG_W+OFS_W-1:OFS_W] == $past(seg_i)));

    p_nest_up_r8: assert property (@(posedge clk) disable iff (rst)
        (req_o && prio_o != 2'd0) |=> (!(req_o && prio_o != 2'd0) || (prio_o > $past(prio_o))));

    p_block_r9: assert property (@(posedge clk) disable iff (rst)
        (req_o && prio_o != 2'd0) |-> irq_block_o);
endmodule

bind trap_ctrl trap_ctrl_chk #(.SEG_W(SEG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .clr_we_i    (clr_we_i),
    .clr_mask_i  (clr_mask_i),
    .seg_i       (seg_i),
    .flags_o     (flags_o),
    .req_o       (req_o),
    .trap_num_o  (trap_num_o),
    .prio_o      (prio_o),
    .vec_addr_o  (vec_addr_o),
    .irq_block_o (irq_block_o)
);

// File: tb/tb_trap_ctrl.sv
`timescale 1ns/1ps
module tb_trap_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  evt_i;
    logic        rst_evt_i;
    logic        clr_we_i;
    logic [7:0]  clr_mask_i;
    logic        sw_trap_i;
    logic [6:0]  sw_num_i;
    logic        ret_i;
    logic [7:0]  seg_i;
    logic [7:0]  flags_o;
    logic        req_o;
    logic [6:0]  trap_num_o;
    logic [1:0]  prio_o;
    logic [23:0] vec_addr_o;
    logic        irq_block_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    trap_ctrl dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .rst_evt_i(rst_evt_i),
        .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i), .sw_trap_i(sw_trap_i),
        .sw_num_i(sw_num_i), .ret_i(ret_i), .seg_i(seg_i), .flags_o(flags_o),
        .req_o(req_o), .trap_num_o(trap_num_o), .prio_o(prio_o),
        .vec_addr_o(vec_addr_o), .irq_block_o(irq_block_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic [7:0] m);
        evt_i = m; step(); evt_i = '0;
    endtask

    task automatic pulse_ret();
        ret_i = 1'b1; step(); ret_i = 1'b0;
    endtask

    task automatic pulse_clr(input logic [7:0] m);
        clr_we_i = 1'b1; clr_mask_i = m; step(); clr_we_i = 1'b0; clr_mask_i = '0;
    endtask

    task automatic drain();
        for (int k = 0; k < 8; k++) if (irq_block_o) pulse_ret();
        step();
    endtask

    // request check: trap number, priority and vector from arithmetic
    task automatic chk_req(input string tag, input int num, input int pr);
        chk({tag, " req"}, req_o, 1);
        chk({tag, " num"}, trap_num_o, num);
        chk({tag, " prio"}, prio_o, pr);
        chk({tag, " vec R6"}, vec_addr_o, (int'(seg_i) << 16) | (num * 4));
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; evt_i = '0; rst_evt_i = 1'b0; clr_we_i = 1'b0; clr_mask_i = '0;
        sw_trap_i = 1'b0; sw_num_i = '0; ret_i = 1'b0; seg_i = 8'h00;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("reset flags", flags_o, 0);
        chk("reset req", req_o, 0);
        chk("reset R9 block", irq_block_o, 0);

        // single causes: R1 R4 R5 R10 R9
        for (int b = 0; b < 8; b++) begin
            seg_i = 8'h30 + 8'(b);
            pulse_evt(8'(1 << b));
            chk("R10 no early req", req_o, 0);
            step();
            if (b < 4) chk_req("R4 single", 2 + 2 * b, 2);
            else       chk_req("R5 single", 10, 1);
            chk("R9 block on", irq_block_o, 1);
            chk("R1 flag set", flags_o, 1 << b);
            step();
            chk("R10 one cycle", req_o, 0);
            pulse_ret();
            chk("R9 block off", irq_block_o, 0);
            pulse_clr(8'(1 << b));
            chk("R1 flag cleared", flags_o, 0);
        end

        // all class-A subsets: lowest number first, same class waits (R4 R8)
        for (int s = 1; s < 16; s++) begin
            seg_i = 8'(s);
            pulse_evt(8'(s));
            for (int i = 0; i < 4; i++) begin
                if (s[i]) begin
                    step();
                    chk_req("R4 order", 2 + 2 * i, 2);
                    step();
                    chk("R8 same class blocked", req_o, 0);
                    pulse_ret();
                end
            end
            step();
            chk("R4 subset drained", req_o, 0);
            chk("R4 subset block off", irq_block_o, 0);
            chk("R1 subset flags", flags_o, s);
            pulse_clr(8'(s));
        end

        // class B together: one shared request, all flags kept (R5)
        pulse_evt(8'hF0);
        step();
        chk_req("R5 shared", 10, 1);
        step();
        chk("R5 no second", req_o, 0);
        pulse_ret();
        step();
        chk("R5 none after ret", req_o, 0);
        chk("R5 flags kept", flags_o, 8'hF0);
        pulse_clr(8'hF0);

        // nesting (R8, R3)
        seg_i = 8'hA5;
        pulse_evt(8'h10); step(); chk_req("R8 base B", 10, 1); step();
        pulse_evt(8'h01); step(); chk_req("R8 A over B", 2, 2); step();
        rst_evt_i = 1'b1; step(); rst_evt_i = 1'b0;
        step(); chk_req("R3 reset class", 0, 3); step();
        pulse_evt(8'h02); step(); chk("R8 A under reset", req_o, 0);
        step(); chk("R8 still blocked", req_o, 0);
        pulse_ret(); step(); chk("R8 A equal A", req_o, 0);
        pulse_ret(); step(); chk_req("R8 A after rets", 4, 2);
        drain();
        chk("R9 nest drained", irq_block_o, 0);
        pulse_clr(8'hFF);

        // class A active, class B waits (R8)
        pulse_evt(8'h01); step(); chk_req("R8 A active", 2, 2);
        pulse_evt(8'h20); step(); chk("R8 B under A", req_o, 0);
        pulse_ret(); step(); chk_req("R8 B after ret", 10, 1);
        drain();
        pulse_clr(8'hFF);

        // R2 clear vs event
        pulse_evt(8'h08); step(); drain();
        clr_we_i = 1'b1; clr_mask_i = 8'h08; evt_i = 8'h08;
        step();
        clr_we_i = 1'b0; clr_mask_i = '0; evt_i = '0;
        chk("R2 event wins", flags_o, 8'h08);
        step(); drain();
        pulse_clr(8'h01);
        chk("R1 other bits untouched", flags_o, 8'h08);
        pulse_clr(8'h08);
        chk("R1 clear alone", flags_o, 0);

        // software trap sweep (R7)
        for (int n = 0; n < 128; n++) begin
            seg_i = 8'(255 - n);
            sw_trap_i = 1'b1; sw_num_i = 7'(n); step(); sw_trap_i = 1'b0;
            step();
            chk_req("R7 sw", n, 0);
            chk("R7 no block", irq_block_o, 0);
        end
        step();
        chk("R7 sw done", req_o, 0);

        // hardware and software together (R11)
        seg_i = 8'h5A;
        sw_trap_i = 1'b1; sw_num_i = 7'h55; evt_i = 8'h01;
        step();
        sw_trap_i = 1'b0; evt_i = '0;
        step(); chk_req("R11 hw first", 2, 2);
        step(); chk_req("R11 sw second", 7'h55, 0);
        step(); chk("R11 quiet", req_o, 0);
        drain();
        pulse_clr(8'hFF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule